// File: doc/BRIEF.md
# Instruction Record and Replay Fetch Unit

This unit sits in the fetch stage of a processor. It lets a program capture a short straight-line run of instructions in small on-chip buffers and later expand one control instruction into that run, repeated as often as needed. The unit takes a stream of fetched words with a valid flag, and each word carries a control code that decode has already extracted. It passes ordinary words on to decode, diverts them into a buffer while capturing, and injects buffered words in place of fetched ones while replaying.

Three control codes steer it. A capture command picks a buffer, empties it and diverts the following words into it. An end command returns the unit to pass-through. A replay command names a buffer and a repeat count. It raises a program-counter hold, spends one cycle on set-up, then issues the buffer contents in order the requested number of times, waiting on a ready signal from decode. Afterwards it drops the hold, so fetch carries on from where it stopped. The stored words are opaque, so words that drive custom execution units are captured and replayed like any others.

The buffer count and depth are parameters, and both must be powers of two. The default is 4 buffers of 16 words. A single buffer of 64 words is also a supported build.

Top module: `irf_replay`

## Requirements
- R1: After reset `issue_valid` and `pc_freeze` are 0. In pass-through mode, a valid fetched word with control code 0 (plain) appears on `issue_instr`, unchanged and with `issue_valid` high, one clock edge after it is sampled.
- R2: Control code 1 (capture) in pass-through mode empties buffer `ctl_sel` and enters capture mode. Each later plain word is written to the buffer's next entry, and no word reaches the issue port while capturing.
- R3: Control code 2 (end) in capture mode is not stored. It returns the unit to pass-through, so the next plain word is issued again.
- R4: The fill count of a buffer wraps to zero after BUF_DEPTH stored words. Capturing BUF_DEPTH+k words therefore leaves k valid entries, holding the last k words.
- R5: Control code 3 (replay) issues entries 0 to count-1 of the selected buffer in order, and repeats the whole run `ctl_reps` times.
- R6: `pc_freeze` is high from the edge that accepts a replay until the last replayed word has been accepted. Fetched words presented during that time are ignored. Afterwards plain words issue normally again.
- R7: A replay spends exactly one idle set-up cycle. The first replayed word is valid two edges after the replay word's edge. With `issue_ready` held high, `pc_freeze` stays high for count*reps+2 cycles.
- R8: A replay of an empty buffer, or one with a repeat count of 0, issues nothing and holds `pc_freeze` for exactly one cycle.
- R9: While replaying, a word held with `issue_ready` low stays valid and unchanged. Stall cycles advance neither the entry index nor the repeat count.
- R10: A control word arriving in the wrong mode is dropped with no effect: end in pass-through, and capture or replay while capturing. Control words are never issued.
- R11: The buffer selector is taken modulo NUM_BUFS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetched word present |
| fetch_instr | input | IW | Fetched instruction word |
| ctl_op | input | 2 | Decoded control code: 0 plain, 1 capture, 2 end, 3 replay |
| ctl_sel | input | SEL_W | Buffer selector for capture and replay |
| ctl_reps | input | REP_W | Repeat count for replay |
| issue_ready | input | 1 | Decode accepts the issued word |
| issue_valid | output | 1 | Issued word valid |
| issue_instr | output | IW | Issued instruction word |
| pc_freeze | output | 1 | Hold the program counter and fetch |

## Verification
A plain word is due on the issue port one edge after it is sampled. A replay shows an idle set-up cycle, and its first word is due on the second edge. The hold stays high for count*reps+2 cycles when decode never stalls, and for exactly one cycle when the replay is empty. Inputs change on the falling edge, and every observation is taken one nanosecond later, so each result is read in the half cycle after the rising edge that produced it. A scoreboard queue keeps the order of expected words; the replay task separately checks the idle cycle, the first-word cycle and the hold length, counting falling edges. Stall runs vary the ready signal and inject junk fetches while the hold is high, and the queue shows that nothing was skipped, repeated or leaked.

// File: rtl/irf_pkg.sv
package irf_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_REC  = 2'd1,
    OP_STOP = 2'd2,
    OP_PLAY = 2'd3
  } ctl_op_e;

  typedef enum logic [2:0] {
    M_NORM  = 3'd0,
    M_REC   = 3'd1,
    M_OVH   = 3'd2,
    M_PLAY  = 3'd3,
    M_DRAIN = 3'd4
  } mode_e;
endpackage

// File: rtl/irf_store.sv
module irf_store #(
  parameter int WORDS = 64,
  parameter int IW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  logic [IW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/irf_counts.sv
module irf_counts #(
  parameter int NB   = 4,
  parameter int ND   = 16,
  localparam int BW  = (NB > 1) ? $clog2(NB) : 1,
  localparam int PW  = $clog2(ND)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [BW-1:0]   clr_sel,
  input  logic            inc,
  input  logic [BW-1:0]   inc_sel,
  output logic [NB*PW-1:0] cnt_flat
);
  for (genvar g = 0; g < NB; g++) begin : g_cnt
    logic [PW-1:0] c;
    always_ff @(posedge clk) begin
      if (rst) c <= '0;
      else if (clr && clr_sel == BW'(g)) c <= '0;
      else if (inc && inc_sel == BW'(g)) c <= c + 1'b1;
    end
    assign cnt_flat[g*PW +: PW] = c;

    a_r2_clear_count: assert property (@(posedge clk) disable iff (rst)
      (clr && clr_sel == BW'(g)) |=> (c == '0));
  end
endmodule

// File: rtl/irf_seq.sv
module irf_seq
  import irf_pkg::*;
#(
  parameter int NB   = 4,
  parameter int ND   = 16,
  parameter int IW   = 32,
  parameter int CW   = 8,
  parameter int SW   = 4,
  localparam int BW  = (NB > 1) ? $clog2(NB) : 1,
  localparam int PW  = $clog2(ND),
  localparam int AW  = $clog2(NB * ND)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_valid,
  input  logic [IW-1:0] fetch_instr,
  input  ctl_op_e       ctl_op,
  input  logic [SW-1:0] ctl_sel,
  input  logic [CW-1:0] ctl_reps,
  input  logic          issue_ready,
  input  logic [PW-1:0] cnt_cur,
  input  logic [IW-1:0] rd_data,
  output logic [BW-1:0] cur_buf,
  output logic [BW-1:0] clr_sel,
  output logic          clr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          issue_valid,
  output logic [IW-1:0] issue_instr,
  output logic          pc_freeze
);
  mode_e         mode;
  logic [PW-1:0] ptr;
  logic [CW-1:0] rep, reps;
  logic [BW-1:0] sel_mod;
  logic          slot_free, last_entry, last_rep;

  assign sel_mod    = BW'(ctl_sel % SW'(NB));
  assign clr_sel    = sel_mod;
  assign clr        = (mode == M_NORM) && fetch_valid && (ctl_op == OP_REC);
  assign we         = (mode == M_REC) && fetch_valid && (ctl_op == OP_NONE);
  assign slot_free  = !issue_valid || issue_ready;
  assign last_entry = (ptr == cnt_cur - 1'b1);
  assign last_rep   = (rep == reps - 1'b1);
  assign pc_freeze  = (mode == M_OVH) || (mode == M_PLAY) || (mode == M_DRAIN);

  if (NB > 1) begin : g_multi
    assign waddr = {cur_buf, cnt_cur};
    assign raddr = {cur_buf, ptr};
  end else begin : g_single
    assign waddr = cnt_cur;
    assign raddr = ptr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode        <= M_NORM;
      cur_buf     <= '0;
      ptr         <= '0;
      rep         <= '0;
      reps        <= '0;
      issue_valid <= 1'b0;
      issue_instr <= '0;
    end else begin
      case (mode)
        M_NORM: begin
          issue_valid <= fetch_valid && (ctl_op == OP_NONE);
          if (fetch_valid) begin
            case (ctl_op)
              OP_NONE: issue_instr <= fetch_instr;
              OP_REC: begin
                cur_buf <= sel_mod;
                mode    <= M_REC;
              end
              OP_PLAY: begin
                cur_buf <= sel_mod;
                reps    <= ctl_reps;
                mode    <= M_OVH;
              end
              default: ;
            endcase
          end
        end
        M_REC: begin
          issue_valid <= 1'b0;
          if (fetch_valid && ctl_op == OP_STOP) mode <= M_NORM;
        end
        M_OVH: begin
          ptr  <= '0;
          rep  <= '0;
          mode <= (cnt_cur == '0 || reps == '0) ? M_NORM : M_PLAY;
        end
        M_PLAY: begin
          if (slot_free) begin
            issue_valid <= 1'b1;
            issue_instr <= rd_data;
            if (last_entry) begin
              ptr <= '0;
              if (last_rep) mode <= M_DRAIN;
              else rep <= rep + 1'b1;
            end else begin
              ptr <= ptr + 1'b1;
            end
          end
        end
        M_DRAIN: begin
          if (issue_ready) begin
            issue_valid <= 1'b0;
            mode        <= M_NORM;
          end
        end
        default: mode <= M_NORM;
      endcase
    end
  end

  a_r1_pass_through: assert property (@(posedge clk) disable iff (rst)
    (mode == M_NORM && fetch_valid && ctl_op == OP_NONE)
      |=> (issue_valid && issue_instr == $past(fetch_instr)));

  a_r2_silent_capture: assert property (@(posedge clk) disable iff (rst)
    (mode == M_REC) |-> !issue_valid);

  a_r3_end_capture: assert property (@(posedge clk) disable iff (rst)
    (mode == M_REC && fetch_valid && ctl_op == OP_STOP)
      |=> (!pc_freeze && !issue_valid && !we));

  a_r5_index_in_range: assert property (@(posedge clk) disable iff (rst)
    (mode == M_PLAY) |-> (ptr < cnt_cur));

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !issue_ready && pc_freeze)
      |=> (issue_valid && $stable(issue_instr)));
endmodule

// File: rtl/irf_replay.sv
module irf_replay
  import irf_pkg::*;
#(
  parameter int NUM_BUFS  = 4,
  parameter int BUF_DEPTH = 16,
  parameter int IW        = 32,
  parameter int REP_W     = 8,
  parameter int SEL_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_valid,
  input  logic [IW-1:0]    fetch_instr,
  input  logic [1:0]       ctl_op,
  input  logic [SEL_W-1:0] ctl_sel,
  input  logic [REP_W-1:0] ctl_reps,
  input  logic             issue_ready,
  output logic             issue_valid,
  output logic [IW-1:0]    issue_instr,
  output logic             pc_freeze
);
  localparam int BW    = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1;
  localparam int PW    = $clog2(BUF_DEPTH);
  localparam int WORDS = NUM_BUFS * BUF_DEPTH;
  localparam int AW    = $clog2(WORDS);

  logic [BW-1:0]          cur_buf, clr_sel;
  logic                   clr, we;
  logic [AW-1:0]          waddr, raddr;
  logic [IW-1:0]          rd_data;
  logic [NUM_BUFS*PW-1:0] cnt_flat;
  logic [PW-1:0]          cnt_cur;

  assign cnt_cur = cnt_flat[int'(cur_buf)*PW +: PW];

  irf_counts #(.NB(NUM_BUFS), .ND(BUF_DEPTH)) u_counts (
    .clk(clk), .rst(rst),
    .clr(clr), .clr_sel(clr_sel),
    .inc(we), .inc_sel(cur_buf),
    .cnt_flat(cnt_flat)
  );

  irf_store #(.WORDS(WORDS), .IW(IW)) u_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(fetch_instr),
    .raddr(raddr), .rdata(rd_data)
  );

  irf_seq #(.NB(NUM_BUFS), .ND(BUF_DEPTH), .IW(IW), .CW(REP_W), .SW(SEL_W)) u_seq (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_instr(fetch_instr),
    .ctl_op(ctl_op_e'(ctl_op)), .ctl_sel(ctl_sel), .ctl_reps(ctl_reps),
    .issue_ready(issue_ready),
    .cnt_cur(cnt_cur), .rd_data(rd_data),
    .cur_buf(cur_buf), .clr_sel(clr_sel), .clr(clr), .we(we),
    .waddr(waddr), .raddr(raddr),
    .issue_valid(issue_valid), .issue_instr(issue_instr),
    .pc_freeze(pc_freeze)
  );
endmodule

// File: tb/irf_replay_test.sv
`timescale 1ns/1ps
module irf_replay_test;
  localparam int NB = 4, ND = 16, IW = 32, CW = 8, SW = 4;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic          fetch_valid = 1'b0;
  logic [IW-1:0] fetch_instr = '0;
  logic [1:0]    ctl_op = 2'd0;
  logic [SW-1:0] ctl_sel = '0;
  logic [CW-1:0] ctl_reps = '0;
  logic          issue_ready = 1'b1;
  logic          issue_valid, pc_freeze;
  logic [IW-1:0] issue_instr;

  irf_replay #(.NUM_BUFS(NB), .BUF_DEPTH(ND), .IW(IW), .REP_W(CW), .SEL_W(SW)) uut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_instr(fetch_instr),
    .ctl_op(ctl_op), .ctl_sel(ctl_sel), .ctl_reps(ctl_reps),
    .issue_ready(issue_ready), .issue_valid(issue_valid),
    .issue_instr(issue_instr), .pc_freeze(pc_freeze)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  logic [IW-1:0] exp_q[$];
  string tag_q[$];
  logic [IW-1:0] mbuf [NB][ND];
  int mcnt [NB];
  bit capturing = 0;
  int cap_buf = 0;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    #1;
    if (!rst && issue_valid && issue_ready) begin
      if (exp_q.size() == 0) check(0, "R2", "unexpected issued word", issue_instr, 0);
      else begin
        logic [IW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(issue_instr == e, t, "issued word", issue_instr, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      summary();
    end
  end

  task automatic drive(logic [1:0] op, logic [IW-1:0] w, int sel, int reps);
    @(negedge clk);
    fetch_valid = 1'b1; ctl_op = op; fetch_instr = w;
    ctl_sel = SW'(sel); ctl_reps = CW'(reps);
    @(negedge clk);
    fetch_valid = 1'b0; ctl_op = 2'd0;
  endtask

  task automatic word(logic [IW-1:0] w, string tag);
    if (capturing) begin
      mbuf[cap_buf][mcnt[cap_buf]] = w;
      mcnt[cap_buf] = (mcnt[cap_buf] + 1) % ND;
    end else begin
      exp_q.push_back(w); tag_q.push_back(tag);
    end
    drive(2'd0, w, 0, 0);
  endtask

  task automatic capture(int sel);
    if (!capturing) begin
      capturing = 1; cap_buf = sel % NB; mcnt[cap_buf] = 0;
    end
    drive(2'd1, 32'hC0DE_0001, sel, 0);
  endtask

  task automatic finish_capture();
    capturing = 0;
    drive(2'd2, 32'hC0DE_0002, 0, 0);
  endtask

  task automatic replay(int sel, int reps, bit stall, bit junk, string tag);
    int b, len, pos, held;
    bit busy;
    b = sel % NB; len = mcnt[b];
    busy = (len > 0) && (reps > 0);
    for (int r = 0; r < reps; r++)
      for (int j = 0; j < len; j++) begin
        exp_q.push_back(mbuf[b][j]); tag_q.push_back(tag);
      end
    @(negedge clk);
    fetch_valid = 1'b1; ctl_op = 2'd3; fetch_instr = 32'hC0DE_0003;
    ctl_sel = SW'(sel); ctl_reps = CW'(reps);
    @(negedge clk);
    fetch_valid = 1'b0; ctl_op = 2'd0;
    #1;
    check(pc_freeze == 1'b1, "R6", "hold raised after replay", pc_freeze, 1);
    pos = 1; held = 1;
    forever begin
      @(negedge clk);
      issue_ready = stall ? ((pos % 3) != 1) : 1'b1;
      if (junk) begin
        fetch_valid = 1'b1; ctl_op = 2'd0; fetch_instr = 32'hBAD0_0000 + pos;
      end
      #1;
      pos++;
      if (busy && pos == 2) check(!issue_valid, "R7", "idle set-up cycle", issue_valid, 0);
      if (busy && pos == 3) check(issue_valid, "R7", "first replayed word due", issue_valid, 1);
      if (!pc_freeze || pos > 5000) break;
      held++;
    end
    fetch_valid = 1'b0; issue_ready = 1'b1;
    if (!stall) begin
      if (busy) check(held == len * reps + 2, "R7", "hold length", held, len * reps + 2);
      else check(held == 1, "R8", "empty replay hold length", held, 1);
    end
  endtask

  initial begin
    for (int i = 0; i < NB; i++) mcnt[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(issue_valid == 1'b0, "R1", "reset issue_valid", issue_valid, 0);
    check(pc_freeze == 1'b0, "R1", "reset pc_freeze", pc_freeze, 0);

    word(32'h1000_0001, "R1");
    word(32'h1000_0002, "R1");
    drive(2'd2, 32'hDEAD_0002, 0, 0);          // end in pass-through: dropped (R10)
    word(32'h1000_0003, "R10");

    capture(1);
    word(32'h2000_0000, "R2");
    word(32'h2000_0001, "R2");
    drive(2'd3, 32'hDEAD_0003, 2, 5);          // replay while capturing: dropped (R10)
    capture(3);                                 // capture while capturing: dropped (R10)
    word(32'h2000_0002, "R2");
    word(32'h2000_0003, "R2");
    word(32'h2000_0004, "R2");
    finish_capture();
    word(32'h1000_0004, "R3");

    capture(6);                                 // 6 mod 4 = buffer 2 (R11)
    word(32'h3000_0000, "R11");
    word(32'h3000_0001, "R11");
    word(32'h3000_0002, "R11");
    finish_capture();

    replay(1, 3, 0, 0, "R5");
    word(32'h1000_0005, "R6");
    replay(2, 2, 0, 0, "R11");
    replay(3, 4, 0, 0, "R8");
    replay(1, 0, 0, 0, "R8");
    word(32'h1000_0006, "R8");

    capture(0);
    for (int k = 0; k < ND + 2; k++) word(32'h4000_0000 + k, "R4");
    finish_capture();
    replay(0, 1, 0, 0, "R4");

    replay(1, 2, 1, 1, "R9");
    word(32'h1000_0007, "R6");
    replay(4, 1, 0, 0, "R11");                 // 4 mod 4 = buffer 0

    repeat (6) @(negedge clk);
    #1;
    check(exp_q.size() == 0, "R5", "words still owed", exp_q.size(), 0);
    check(pc_freeze == 1'b0, "R6", "hold released at end", pc_freeze, 0);
    summary();
  end
endmodule